// File: doc/BRIEF.md
# Seven-Bit Bidirectional GPIO Port

This block is one general-purpose I/O port of seven pins. It holds a direction register and an output latch, and it samples the pad inputs through a two-flop synchronizer. A small register bus reaches three registers: the pin view, the latch view and the direction view. The bus has an address, a write enable, write data and combinational read data. The block drives per-bit output-enable and output-data lines to tri-state pads. One bit, the open-drain bit, can only pull its line low.

An external configuration source supplies a per-bit analog-select mask, which the block samples every cycle. A pin marked analog reads as 0 through the pin view. Its output driver still follows its direction bit. After reset that source is expected to mark bits 5 and 3..0 as analog and bits 6 and 4 as digital. The synchronized level of bit 4 also leaves the block as a clock-input signal for a neighbouring counter.

Register address map (2-bit address): 0 = pin view, 1 = latch view, 2 = direction view, 3 = unmapped. In the direction register, 1 means input and 0 means output.

There is no sequencing in this block. Its only behaviour over time is register storage and the synchronizer delay.

Top module: `gpio_port`

## Requirements
- R1: While reset is asserted and after its release, the direction register holds all ones (7'h7F) and the latch holds 7'h00. Every pad_oe bit is therefore 0.
- R2: For every bit other than bit 4, pad_oe is 1 exactly when the direction bit is 0, and pad_out equals that bit of the latch.
- R3: A write to address 0 (pin view) loads the latch on the next rising edge and leaves the direction register unchanged.
- R4: A read of address 1 returns the latch contents, not the pad levels, even when the two differ.
- R5: A read of address 0 returns each pad level two rising edges after it is applied. After a single edge it still returns the previous value.
- R6: On a read of address 0, each bit whose analog_sel bit is 1 reads 0. A change of analog_sel alters this read in the same cycle and never changes the latch.
- R7: Bit 4 is open drain. pad_out[4] is always 0, and pad_oe[4] is 1 only when direction bit 4 is 0 and latch bit 4 is 0.
- R8: A pin marked analog keeps driving according to its direction bit and latch bit.
- R9: Address 3 reads 0, and a write to it changes neither the latch nor the direction register.
- R10: ext_clk_in equals pad_in[4] delayed by two rising edges.
- R11: A write to address 2 loads the direction register on the next rising edge. A read of address 2 returns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_we | input | 1 | Write enable, effective at the rising edge |
| bus_wdata | input | 7 | Write data |
| bus_rdata | output | 7 | Read data for bus_addr, combinational |
| analog_sel | input | 7 | Per-bit analog-select mask, 1 = analog |
| pad_in | input | 7 | Asynchronous pad input levels |
| pad_oe | output | 7 | Per-bit pad output enable |
| pad_out | output | 7 | Per-bit pad output data |
| ext_clk_in | output | 1 | Synchronized level of pad bit 4 |

## Verification
A table of four vectors combines direction, latch, analog mask and pad patterns. Some bits in each vector are driven, some are analog inputs with pads high, and some have latch and pad disagreeing. Together they separate the pin view from the latch view and the analog gating from the pad gating. The vectors cover the open-drain bit as an output with latch 0, as an output with latch 1, and as an input. This tells the pull-low-only rule apart from the push-pull rule. Directed tests then cover the following:
- the reset values;
- the one-edge and two-edge synchronizer lag;
- a change of the analog mask within a single cycle, with the latch read back afterwards;
- a pin-view write that must leave the direction register intact;
- writes to the unmapped address.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PIN  = 2'd0,
        REG_LAT  = 2'd1,
        REG_DIR  = 2'd2,
        REG_NONE = 2'd3
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                if (s == 0) begin
                    stage_q[s] <= d_async;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    end

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  lat_q
);
    gpio_reg_e sel;
    logic      wr_lat;
    logic      wr_dir;

    always_comb begin
        sel    = gpio_reg_e'(bus_addr);
        wr_lat = 1'b0;
        wr_dir = 1'b0;
        unique case (sel)
            REG_PIN:  wr_lat = bus_we;
            REG_LAT:  wr_lat = bus_we;
            REG_DIR:  wr_dir = bus_we;
            REG_NONE: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '1;
            lat_q <= '0;
        end else begin
            if (wr_dir) dir_q <= bus_wdata;
            if (wr_lat) lat_q <= bus_wdata;
        end
    end

    // R3: a pin-view write leaves the direction register alone
    a_r3_pin_write_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_PIN) |=> $stable(dir_q));

    // R3: a pin-view write lands in the latch
    a_r3_pin_write_sets_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == REG_PIN) |=> (lat_q == $past(bus_wdata)));

    // R9: the unmapped address touches no storage
    a_r9_unmapped_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_NONE) |=> ($stable(dir_q) && $stable(lat_q)));

    // R11: without a direction write the direction register holds
    a_r11_dir_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == REG_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/gpio_pad.sv
module gpio_pad #(
    parameter int WIDTH  = 7,
    parameter int OD_BIT = 4
) (
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] lat_q,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_out
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i == OD_BIT) begin : g_open_drain
            assign pad_oe[i]  = ~dir_q[i] & ~lat_q[i];
            assign pad_out[i] = 1'b0;
        end else begin : g_push_pull
            assign pad_oe[i]  = ~dir_q[i];
            assign pad_out[i] = lat_q[i];
        end
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH       = 7,
    parameter int OD_BIT      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  analog_sel,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_out,
    output logic              ext_clk_in
);
    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] lat_q;
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] pin_view;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .q_sync  (pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .dir_q     (dir_q),
        .lat_q     (lat_q)
    );

    gpio_pad #(.WIDTH(WIDTH), .OD_BIT(OD_BIT)) i_pad (
        .dir_q   (dir_q),
        .lat_q   (lat_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    assign pin_view   = pin_sync & ~analog_sel;
    assign ext_clk_in = pin_sync[OD_BIT];

    always_comb begin
        bus_rdata = '0;
        unique case (gpio_reg_e'(bus_addr))
            REG_PIN:  bus_rdata = pin_view;
            REG_LAT:  bus_rdata = lat_q;
            REG_DIR:  bus_rdata = dir_q;
            REG_NONE: bus_rdata = '0;
        endcase
    end

    // R7: the open-drain bit only ever drives while its latch is low
    a_r7_od_drives_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[OD_BIT] |-> !lat_q[OD_BIT]);

    // R6: analog-selected bits never show up in a pin-view read
    a_r6_analog_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_PIN) |-> ((bus_rdata & analog_sel) == '0));

    // R9: the unmapped address reads zero
    a_r9_unmapped_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_NONE) |-> (bus_rdata == '0));

    // R4: the latch view reflects the stored latch regardless of the pads
    a_r4_latch_view: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REG_LAT) |-> (bus_rdata == lat_q));
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
    localparam int W = 7;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   bus_addr = 2'd0;
    logic         bus_we = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic [W-1:0] analog_sel = 7'h2F;
    logic [W-1:0] pad_in = '0;
    logic [W-1:0] pad_oe;
    logic [W-1:0] pad_out;
    logic         ext_clk_in;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_port i_gpio_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .analog_sel (analog_sel),
        .pad_in     (pad_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out),
        .ext_clk_in (ext_clk_in)
    );

    // dir, lat, analog, pad, exp_pin, exp_oe, exp_out
    localparam logic [6:0] VEC [4][7] = '{
        '{7'h00, 7'h55, 7'h00, 7'h2A, 7'h2A, 7'h6F, 7'h45},
        '{7'h7F, 7'h2A, 7'h2F, 7'h7F, 7'h50, 7'h00, 7'h2A},
        '{7'h0F, 7'h00, 7'h2F, 7'h55, 7'h50, 7'h70, 7'h00},
        '{7'h6F, 7'h10, 7'h00, 7'h13, 7'h13, 7'h00, 7'h00}
    };

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] r;
        // R1: reset values
        repeat (3) @(negedge clk);
        check("R1 oe in reset", pad_oe, 7'h00);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd2, r); check("R1 dir after reset", r, 7'h7F);
        rd(2'd1, r); check("R1 latch after reset", r, 7'h00);
        check("R1 oe after reset", pad_oe, 7'h00);

        // Vector walk: R2 R4 R6 R7 R8 R11
        for (int v = 0; v < 4; v++) begin
            wr(2'd2, VEC[v][0]);
            wr(2'd1, VEC[v][1]);
            analog_sel = VEC[v][2];
            pad_in = VEC[v][3];
            repeat (3) @(negedge clk);
            rd(2'd0, r); check("R6 pin view vector", r, VEC[v][4]);
            rd(2'd1, r); check("R4 latch view vector", r, VEC[v][1]);
            rd(2'd2, r); check("R11 dir view vector", r, VEC[v][0]);
            check("R2 R7 R8 pad_oe vector", pad_oe, VEC[v][5]);
            check("R2 R7 pad_out vector", pad_out, VEC[v][6]);
        end

        // R3: pin-view write loads latch, keeps direction
        wr(2'd2, 7'h0C);
        wr(2'd0, 7'h33);
        rd(2'd1, r); check("R3 latch from pin write", r, 7'h33);
        rd(2'd2, r); check("R3 dir kept", r, 7'h0C);

        // R6: mask change alters pin view at once, latch untouched
        pad_in = 7'h7F; analog_sel = 7'h00;
        repeat (3) @(negedge clk);
        rd(2'd0, r); check("R6 mask clear", r, 7'h7F);
        analog_sel = 7'h2F;
        rd(2'd0, r); check("R6 mask immediate", r, 7'h50);
        rd(2'd1, r); check("R6 latch untouched", r, 7'h33);

        // R5 / R10: two-edge lag
        analog_sel = 7'h00;
        @(negedge clk);
        pad_in = 7'h00;
        @(negedge clk);
        rd(2'd0, r); check("R5 one edge still old", r, 7'h7F);
        check("R10 one edge still old", {6'd0, ext_clk_in}, 7'h01);
        @(negedge clk);
        rd(2'd0, r); check("R5 two edges new", r, 7'h00);
        check("R10 two edges new", {6'd0, ext_clk_in}, 7'h00);

        // R9: unmapped address
        wr(2'd3, 7'h7F);
        rd(2'd3, r); check("R9 unmapped reads zero", r, 7'h00);
        rd(2'd1, r); check("R9 latch unchanged", r, 7'h33);
        rd(2'd2, r); check("R9 dir unchanged", r, 7'h0C);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule